// File: doc/BRIEF.md
# Tagged Fully-Associative Translation Buffer

This block caches virtual-to-physical page translations for a processor memory system. It holds 64 entries, and any entry can hold any page. Each entry maps one page of 4 KB, 64 KB, 1 MB or 16 MB. Each entry also carries an address-space identifier, a global flag, a secure/non-secure tag, a domain number, permission bits and region attributes. A lookup presents a virtual address, the current identifier and the current security state. One cycle later the block reports hit or miss. On a hit it also returns the composed physical address and the entry's domain, permission and attribute fields. On a miss an external table walker fetches the translation and writes it back through the refill port. Three invalidate commands, plus an unlock-and-invalidate command, remove entries.

Slots 0 to 7 form a lockdown region. A refill writes there only when it asks to, naming a slot, and the replacement pointer never visits those slots. A configuration input can limit lockdown writes to secure-world refills.

The result path is a small state machine with three states. RS_IDLE means no result this cycle. RS_HIT means the result is a valid hit. RS_MISS means the result is a valid miss. From any state, the next state is RS_HIT when a lookup is presented and an entry matches. It is RS_MISS when a lookup is presented and no entry matches. It is RS_IDLE when no lookup is presented.

Top module: `tlb_top`

## Requirements
- R1: The page size code in an entry sets which bits of the virtual page number are compared and which bits of the physical address come from the virtual address. The codes are 0 = 4 KB (all 20 bits compared), 1 = 64 KB (low 4 bits ignored), 2 = 1 MB (low 8 bits ignored) and 3 = 16 MB (low 12 bits ignored). The physical address takes its masked upper bits from the entry and the remaining bits from the virtual address.
- R2: An entry hits only if its global flag is set or its stored identifier equals the lookup identifier. Changing the lookup identifier changes which non-global entries hit, without any invalidation.
- R3: An entry hits only if its secure tag equals the lookup security state. Secure and non-secure entries for the same page can be present at the same time.
- R4: The result is registered. `res_valid` is 1 exactly in the cycle after a cycle with `lk_valid` = 1. On a miss, and whenever there is no hit, `res_pa`, `res_dom`, `res_perm` and `res_rattr` are zero.
- R5: If several entries match, the entry with the lowest index supplies the result. Lockdown slots therefore take priority over unlocked slots.
- R6: A refill with `rf_lock` = 0 writes the slot under a round-robin pointer. The pointer starts at slot 8 after reset and steps through slots 8 to 63, then wraps to 8. It never points at a lockdown slot.
- R7: A refill with `rf_lock` = 1 writes lockdown slot `rf_lock_slot`. While `cfg_lock_secure` = 1, such a refill with `rf_secure` = 0 is dropped.
- R8: `inv_op` selects the invalidate command. Code 0 clears all unlocked entries. Code 1 clears unlocked non-global entries whose identifier equals `inv_asid`. Code 2 clears unlocked entries whose page, masked by the entry's size, matches `inv_vpn`. Code 3 clears every entry, locked ones included.
- R9: After reset no entry is valid, `res_valid` is 0 and every lookup misses.
- R10: An invalidate and a refill in the same cycle apply only the invalidate. A lookup in the same cycle as an update sees the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lock_secure | input | 1 | Limits lockdown writes to secure refills |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Current address-space identifier |
| lk_secure | input | 1 | Current security state (1 = secure) |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_ppn | input | 20 | Refill physical page number |
| rf_size | input | 2 | Refill page size code |
| rf_asid | input | 8 | Refill identifier |
| rf_global | input | 1 | Refill global flag |
| rf_secure | input | 1 | Refill secure tag |
| rf_dom | input | 4 | Refill domain number |
| rf_perm | input | 3 | Refill permission bits |
| rf_rattr | input | 5 | Refill region attributes |
| rf_lock | input | 1 | Write into the lockdown region |
| rf_lock_slot | input | 3 | Lockdown slot to write |
| inv_valid | input | 1 | Invalidate request |
| inv_op | input | 2 | Invalidate command code |
| inv_asid | input | 8 | Identifier for command 1 |
| inv_vpn | input | 20 | Page number for command 2 |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Result is a hit |
| res_pa | output | 32 | Translated physical address |
| res_dom | output | 4 | Domain of the hit entry |
| res_perm | output | 3 | Permission bits of the hit entry |
| res_rattr | output | 5 | Region attributes of the hit entry |

## Verification
Every cycle, the assertions check these properties:
- the one-cycle result timing, and zeroed fields on a miss;
- that the lowest matching index is chosen;
- that the replacement pointer stays in the unlocked pool and steps correctly;
- that a blocked non-secure lockdown write leaves the locked slots unchanged;
- that clear-all empties the unlocked pool.

Only the bench's scenarios can show the rest. This covers address composition for each page size, identifier and security qualification, and the eviction order after the pool wraps. It also covers survival of locked entries through ordinary invalidates, and the same-cycle ordering of lookup, refill and invalidate. The bench checks these against its behavioural model on every clock.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W    = 32;
    localparam int OFS_W   = 12;
    localparam int VPN_W   = VA_W - OFS_W;
    localparam int ASID_W  = 8;
    localparam int DOM_W   = 4;
    localparam int PERM_W  = 3;
    localparam int RATTR_W = 5;

    typedef enum logic [1:0] {PG_4K = 2'd0, PG_64K = 2'd1, PG_1M = 2'd2, PG_16M = 2'd3} pg_size_e;
    typedef enum logic [1:0] {INV_ALL = 2'd0, INV_ASID = 2'd1, INV_VA = 2'd2, INV_UNLOCK_ALL = 2'd3} inv_op_e;
    typedef enum logic [1:0] {RS_IDLE = 2'd0, RS_HIT = 2'd1, RS_MISS = 2'd2} res_state_e;

    typedef struct packed {
        logic                valid;
        logic [VPN_W-1:0]    vpn;
        logic [VPN_W-1:0]    ppn;
        pg_size_e            size;
        logic [ASID_W-1:0]   asid;
        logic                glob;
        logic                secure;
        logic [DOM_W-1:0]    dom;
        logic [PERM_W-1:0]   perm;
        logic [RATTR_W-1:0]  rattr;
    } tlb_ent_t;

    // Bits of the page number that take part in comparison for a given size.
    function automatic logic [VPN_W-1:0] page_mask(pg_size_e s);
        logic [VPN_W-1:0] m;
        unique case (s)
            PG_4K:   m = {VPN_W{1'b1}};
            PG_64K:  m = {VPN_W{1'b1}} << 4;
            PG_1M:   m = {VPN_W{1'b1}} << 8;
            default: m = {VPN_W{1'b1}} << 12;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/tlb_prio.sv
module tlb_prio #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is the last assignment.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = i[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N  = 64,
    parameter int L  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [IW-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= IW'(L);
        end else if (adv) begin
            ptr <= (ptr == IW'(N - 1)) ? IW'(L) : ptr + 1'b1;
        end
    end

    assert_ptr_in_pool_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr >= IW'(L)) && (ptr <= IW'(N - 1)));

    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (ptr == (($past(ptr) == IW'(N - 1)) ? IW'(L) : $past(ptr) + 1'b1)));
endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
#(
    parameter int N_ENT  = 64,
    parameter int N_LOCK = 8,
    parameter int IDX_W  = $clog2(N_ENT),
    parameter int LIDX_W = $clog2(N_LOCK)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_lock_secure,
    input  logic                lk_valid,
    input  logic [VA_W-1:0]     lk_va,
    input  logic [ASID_W-1:0]   lk_asid,
    input  logic                lk_secure,
    input  logic                rf_valid,
    input  logic [VPN_W-1:0]    rf_vpn,
    input  logic [VPN_W-1:0]    rf_ppn,
    input  logic [1:0]          rf_size,
    input  logic [ASID_W-1:0]   rf_asid,
    input  logic                rf_global,
    input  logic                rf_secure,
    input  logic [DOM_W-1:0]    rf_dom,
    input  logic [PERM_W-1:0]   rf_perm,
    input  logic [RATTR_W-1:0]  rf_rattr,
    input  logic                rf_lock,
    input  logic [LIDX_W-1:0]   rf_lock_slot,
    input  logic                inv_valid,
    input  logic [1:0]          inv_op,
    input  logic [ASID_W-1:0]   inv_asid,
    input  logic [VPN_W-1:0]    inv_vpn,
    output logic                res_valid,
    output logic                res_hit,
    output logic [VA_W-1:0]     res_pa,
    output logic [DOM_W-1:0]    res_dom,
    output logic [PERM_W-1:0]   res_perm,
    output logic [RATTR_W-1:0]  res_rattr
);
    tlb_ent_t          ent [N_ENT];
    logic [N_ENT-1:0]  lk_hit;
    logic [N_ENT-1:0]  inv_hit;
    logic [VPN_W-1:0]  lk_vpn;
    logic              found;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  vic_ptr;
    logic              vic_adv;
    res_state_e        st, st_nx;
    tlb_ent_t          nw;
    logic [VA_W-1:0]   pa_nx;
    logic [VPN_W-1:0]  sel_mask;

    assign lk_vpn = lk_va[VA_W-1:OFS_W];

    // Per-entry compare for lookups and for the by-address invalidate.
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        logic [VPN_W-1:0] m;
        assign m = page_mask(ent[g].size);
        assign lk_hit[g] = ent[g].valid
                        && (((ent[g].vpn ^ lk_vpn) & m) == '0)
                        && (ent[g].glob || (ent[g].asid == lk_asid))
                        && (ent[g].secure == lk_secure);
        assign inv_hit[g] = ent[g].valid && (((ent[g].vpn ^ inv_vpn) & m) == '0);
    end

    tlb_prio #(.N(N_ENT), .IW(IDX_W)) u_prio (
        .req   (lk_hit),
        .found (found),
        .idx   (hit_idx)
    );

    assign vic_adv = rf_valid && !inv_valid && !rf_lock;

    tlb_victim #(.N(N_ENT), .L(N_LOCK), .IW(IDX_W)) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (vic_adv),
        .ptr   (vic_ptr)
    );

    always_comb begin
        nw        = '0;
        nw.valid  = 1'b1;
        nw.vpn    = rf_vpn;
        nw.ppn    = rf_ppn;
        nw.size   = pg_size_e'(rf_size);
        nw.asid   = rf_asid;
        nw.glob   = rf_global;
        nw.secure = rf_secure;
        nw.dom    = rf_dom;
        nw.perm   = rf_perm;
        nw.rattr  = rf_rattr;
    end

    // Entry storage: invalidate has precedence over refill.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) ent[i] <= '0;
        end else if (inv_valid) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (inv_op_e'(inv_op) == INV_UNLOCK_ALL) begin
                    ent[i].valid <= 1'b0;
                end else if (i >= N_LOCK) begin
                    if ((inv_op_e'(inv_op) == INV_ALL)
                        || ((inv_op_e'(inv_op) == INV_ASID) && !ent[i].glob && (ent[i].asid == inv_asid))
                        || ((inv_op_e'(inv_op) == INV_VA) && inv_hit[i]))
                        ent[i].valid <= 1'b0;
                end
            end
        end else if (rf_valid) begin
            if (rf_lock) begin
                if (!cfg_lock_secure || rf_secure) ent[rf_lock_slot] <= nw;
            end else begin
                ent[vic_ptr] <= nw;
            end
        end
    end

    // Result state machine.
    always_comb begin
        st_nx = RS_IDLE;
        if (lk_valid) st_nx = found ? RS_HIT : RS_MISS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RS_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        unique case (st)
            RS_HIT:  begin res_valid = 1'b1; res_hit = 1'b1; end
            RS_MISS: begin res_valid = 1'b1; res_hit = 1'b0; end
            default: begin res_valid = 1'b0; res_hit = 1'b0; end
        endcase
    end

    assign sel_mask = page_mask(ent[hit_idx].size);
    assign pa_nx    = {(ent[hit_idx].ppn & sel_mask) | (lk_vpn & ~sel_mask), lk_va[OFS_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_pa <= '0; res_dom <= '0; res_perm <= '0; res_rattr <= '0;
        end else if (lk_valid && found) begin
            res_pa    <= pa_nx;
            res_dom   <= ent[hit_idx].dom;
            res_perm  <= ent[hit_idx].perm;
            res_rattr <= ent[hit_idx].rattr;
        end else begin
            res_pa <= '0; res_dom <= '0; res_perm <= '0; res_rattr <= '0;
        end
    end

    // Checks.
    logic [N_LOCK-1:0]       lock_vld;
    logic [N_ENT-N_LOCK-1:0] pool_vld;
    for (genvar g = 0; g < N_ENT; g++) begin : g_vld
        if (g < N_LOCK) begin : g_l
            assign lock_vld[g] = ent[g].valid;
        end else begin : g_p
            assign pool_vld[g - N_LOCK] = ent[g].valid;
        end
    end

    assert_result_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    assert_no_stray_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_pa == '0 && res_dom == '0 && res_perm == '0 && res_rattr == '0));

    assert_lowest_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (lk_hit[hit_idx] && ((lk_hit & ~({N_ENT{1'b1}} << hit_idx)) == '0)));

    assert_lock_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && !inv_valid && rf_lock && cfg_lock_secure && !rf_secure)
        |=> (lock_vld == $past(lock_vld)));

    assert_clear_pool_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_op_e'(inv_op) == INV_ALL) |=> (pool_vld == '0));
endmodule

// File: tb/tlb_top_tb.sv
module tlb_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 64;
    localparam int NL = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_lock_secure;
    logic        lk_valid;
    logic [31:0] lk_va;
    logic [7:0]  lk_asid;
    logic        lk_secure;
    logic        rf_valid;
    logic [19:0] rf_vpn, rf_ppn;
    logic [1:0]  rf_size;
    logic [7:0]  rf_asid;
    logic        rf_global, rf_secure;
    logic [3:0]  rf_dom;
    logic [2:0]  rf_perm;
    logic [4:0]  rf_rattr;
    logic        rf_lock;
    logic [2:0]  rf_lock_slot;
    logic        inv_valid;
    logic [1:0]  inv_op;
    logic [7:0]  inv_asid;
    logic [19:0] inv_vpn;
    logic        res_valid, res_hit;
    logic [31:0] res_pa;
    logic [3:0]  res_dom;
    logic [2:0]  res_perm;
    logic [4:0]  res_rattr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_top u_dut (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference model.
    bit mv [NE];
    int mvpn [NE], mppn [NE], msz [NE], masid [NE], mdom [NE], mperm [NE], mrat [NE];
    bit mglob [NE], msec [NE];
    int mptr;
    bit e_valid, e_hit;
    logic [31:0] e_pa;
    logic [11:0] e_attr;

    function automatic int msk(int s);
        return (32'hFFFFF << (4 * s)) & 32'hFFFFF;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NE; i++) mv[i] = 0;
        mptr = NL;
        e_valid = 0; e_hit = 0; e_pa = 0; e_attr = 0;
    endtask

    task automatic model_put(int i);
        mv[i] = 1; mvpn[i] = int'(rf_vpn); mppn[i] = int'(rf_ppn); msz[i] = int'(rf_size);
        masid[i] = int'(rf_asid); mglob[i] = rf_global; msec[i] = rf_secure;
        mdom[i] = int'(rf_dom); mperm[i] = int'(rf_perm); mrat[i] = int'(rf_rattr);
    endtask

    task automatic model_step();
        int v;
        int m;
        v = int'(lk_va[31:12]);
        e_valid = lk_valid; e_hit = 0; e_pa = 0; e_attr = 0;
        if (lk_valid) begin
            for (int i = 0; i < NE; i++) begin
                if (!e_hit && mv[i] && (((mvpn[i] ^ v) & msk(msz[i])) == 0)
                    && (mglob[i] || masid[i] == int'(lk_asid)) && (msec[i] == lk_secure)) begin
                    m = msk(msz[i]);
                    e_hit = 1;
                    e_pa = {20'((mppn[i] & m) | (v & ~m)), lk_va[11:0]};
                    e_attr = {4'(mdom[i]), 3'(mperm[i]), 5'(mrat[i])};
                end
            end
        end
        if (inv_valid) begin
            for (int i = 0; i < NE; i++) begin
                if (inv_op == 2'd3) mv[i] = 0;
                else if (i >= NL) begin
                    if (inv_op == 2'd0) mv[i] = 0;
                    if (inv_op == 2'd1 && !mglob[i] && masid[i] == int'(inv_asid)) mv[i] = 0;
                    if (inv_op == 2'd2 && (((mvpn[i] ^ int'(inv_vpn)) & msk(msz[i])) == 0)) mv[i] = 0;
                end
            end
        end else if (rf_valid) begin
            if (rf_lock) begin
                if (!cfg_lock_secure || rf_secure) model_put(int'(rf_lock_slot));
            end else begin
                model_put(mptr);
                mptr = (mptr == NE - 1) ? NL : mptr + 1;
            end
        end
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic clr();
        lk_valid = 0; lk_va = 0; lk_asid = 0; lk_secure = 0;
        rf_valid = 0; rf_vpn = 0; rf_ppn = 0; rf_size = 0; rf_asid = 0; rf_global = 0;
        rf_secure = 0; rf_dom = 0; rf_perm = 0; rf_rattr = 0; rf_lock = 0; rf_lock_slot = 0;
        inv_valid = 0; inv_op = 0; inv_asid = 0; inv_vpn = 0;
    endtask

    task automatic cyc(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(tag, "res_valid", 32'(res_valid), 32'(e_valid));
        chk(tag, "res_hit", 32'(res_hit), 32'(e_hit));
        chk(tag, "res_pa", res_pa, e_pa);
        chk(tag, "attrs", 32'({res_dom, res_perm, res_rattr}), 32'(e_attr));
        clr();
    endtask

    task automatic look(logic [31:0] va, logic [7:0] asid, logic sec, string tag);
        lk_valid = 1; lk_va = va; lk_asid = asid; lk_secure = sec;
        cyc(tag);
    endtask

    task automatic fill(logic [19:0] vpn, logic [19:0] ppn, logic [1:0] sz, logic [7:0] asid,
                        logic glob, logic sec, logic lock, logic [2:0] slot, string tag);
        rf_valid = 1; rf_vpn = vpn; rf_ppn = ppn; rf_size = sz; rf_asid = asid;
        rf_global = glob; rf_secure = sec; rf_dom = vpn[3:0] ^ 4'h5;
        rf_perm = ppn[2:0]; rf_rattr = vpn[8:4] ^ 5'h0A; rf_lock = lock; rf_lock_slot = slot;
        cyc(tag);
    endtask

    task automatic inval(logic [1:0] op, logic [7:0] asid, logic [19:0] vpn, string tag);
        inv_valid = 1; inv_op = op; inv_asid = asid; inv_vpn = vpn;
        cyc(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clr();
        cfg_lock_secure = 0;
        rst_n = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R9: reset state, empty buffer
        cyc("R9");
        look(32'h1234_5678, 8'd0, 1'b0, "R9");

        // R1: each page size, offsets inside and just outside
        fill(20'h10000, 20'hAAAAA, 2'd0, 8'd0, 1, 0, 0, 3'd0, "R1");
        fill(20'h20010, 20'hBBBB0, 2'd1, 8'd0, 1, 0, 0, 3'd0, "R1");
        fill(20'h30100, 20'hCCC00, 2'd2, 8'd0, 1, 0, 0, 3'd0, "R1");
        fill(20'h45000, 20'hD7000, 2'd3, 8'd0, 1, 0, 0, 3'd0, "R1");
        look(32'h1000_0ABC, 8'd3, 1'b0, "R1");
        look(32'h2001_F123, 8'd3, 1'b0, "R1");
        look(32'h301F_FFFF, 8'd3, 1'b0, "R1");
        look(32'h45AB_CDEF, 8'd3, 1'b0, "R1");
        look(32'h1000_1000, 8'd3, 1'b0, "R1");
        look(32'h2002_0000, 8'd3, 1'b0, "R1");

        // R4: result lasts one cycle, zero fields when idle
        cyc("R4");

        // R2: identifier qualification and global bypass
        fill(20'h50000, 20'h12345, 2'd0, 8'd5, 0, 0, 0, 3'd0, "R2");
        look(32'h5000_0010, 8'd5, 1'b0, "R2");
        look(32'h5000_0010, 8'd6, 1'b0, "R2");
        look(32'h1000_0004, 8'd9, 1'b0, "R2");

        // R3: secure and non-secure entries for one page
        fill(20'h60000, 20'h11111, 2'd0, 8'd0, 1, 1, 0, 3'd0, "R3");
        fill(20'h60000, 20'h22222, 2'd0, 8'd0, 1, 0, 0, 3'd0, "R3");
        look(32'h6000_0333, 8'd0, 1'b1, "R3");
        look(32'h6000_0333, 8'd0, 1'b0, "R3");

        // R5: locked slot wins over later unlocked duplicate
        fill(20'h70000, 20'h33333, 2'd0, 8'd0, 1, 0, 1, 3'd3, "R5");
        fill(20'h70000, 20'h44444, 2'd0, 8'd0, 1, 0, 0, 3'd0, "R5");
        look(32'h7000_0001, 8'd0, 1'b0, "R5");

        // R7: lockdown restricted to secure refills
        cfg_lock_secure = 1;
        fill(20'h71000, 20'h55555, 2'd0, 8'd0, 1, 0, 1, 3'd5, "R7");
        look(32'h7100_0000, 8'd0, 1'b0, "R7");
        fill(20'h71000, 20'h66666, 2'd0, 8'd0, 1, 1, 1, 3'd5, "R7");
        look(32'h7100_0000, 8'd0, 1'b1, "R7");
        cfg_lock_secure = 0;

        // R6: wrap the round-robin pool; locked entries survive
        for (int k = 0; k < 60; k++)
            fill(20'h80000 + 20'(k), 20'(k + 1), 2'd0, 8'd0, 1, 0, 0, 3'd0, "R6");
        look(32'h8000_0000, 8'd0, 1'b0, "R6");
        look(32'h8000_3000, 8'd0, 1'b0, "R6");
        look(32'h8003_B000, 8'd0, 1'b0, "R6");
        look(32'h7000_0000, 8'd0, 1'b0, "R6");
        look(32'h7100_0000, 8'd0, 1'b1, "R6");

        // R8: invalidate commands
        fill(20'h90000, 20'h77777, 2'd0, 8'd7, 0, 0, 0, 3'd0, "R8");
        fill(20'h91000, 20'h88888, 2'd1, 8'd7, 1, 0, 0, 3'd0, "R8");
        inval(2'd1, 8'd7, 20'h0, "R8");
        look(32'h9000_0000, 8'd7, 1'b0, "R8");
        look(32'h9100_5000, 8'd7, 1'b0, "R8");
        inval(2'd2, 8'd0, 20'h9100F, "R8");
        look(32'h9100_5000, 8'd7, 1'b0, "R8");
        inval(2'd2, 8'd0, 20'h70000, "R8");
        look(32'h7000_0000, 8'd0, 1'b0, "R8");
        inval(2'd0, 8'd0, 20'h0, "R8");
        look(32'h8003_B000, 8'd0, 1'b0, "R8");
        look(32'h7000_0000, 8'd0, 1'b0, "R8");
        inval(2'd3, 8'd0, 20'h0, "R8");
        look(32'h7000_0000, 8'd0, 1'b0, "R8");
        look(32'h7100_0000, 8'd0, 1'b1, "R8");

        // R10: same-cycle ordering
        rf_valid = 1; rf_vpn = 20'hA0000; rf_ppn = 20'h99999; rf_global = 1;
        inv_valid = 1; inv_op = 2'd0;
        cyc("R10");
        look(32'hA000_0000, 8'd0, 1'b0, "R10");
        rf_valid = 1; rf_vpn = 20'hB0000; rf_ppn = 20'h0ABCD; rf_global = 1;
        lk_valid = 1; lk_va = 32'hB000_0042;
        cyc("R10");
        look(32'hB000_0042, 8'd0, 1'b0, "R10");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule